// File: doc/BRIEF.md
# Repeating Masked Calendar Alarm

This block holds a programmed alarm time in BCD and compares it, once per half-second tick, against the running calendar. A four-bit interval code decides which calendar fields take part in the comparison. It selects a period from half a second up to one year. A field takes part when it is finer than the chosen period. The weekday is compared only for the weekly period.

Each match produces a single-cycle alarm pulse. A repeat counter limits how many pulses the alarm gives. The alarm can also be set to chime without end.

Software writes the whole configuration in one strobe: the alarm time, the interval code, the repeat count, the chime flag and the enable. Counting runs as follows:
- Each pulse lowers the repeat counter by one.
- When a pulse occurs with the counter at zero and chime off, the alarm switches itself off.
- With chime on, a zero counter wraps to its largest value and the alarm keeps running.

Top module: `rcal_alarm`

## Requirements
- R1: During and after reset, `alm_pulse` and `alm_active` are 0.
- R2: A cycle with `cfg_we` high loads the alarm time, interval code, repeat count, chime flag and enable. From the next cycle, `alm_active` equals the enable value written.
- R3: A pulse needs three things together in one cycle: `alm_active` high, `tick` high, and every selected field equal to the alarm value. The block then drives `alm_pulse` high for exactly the following cycle. Without a tick, no pulse occurs.
- R4: Interval codes select fields as follows. Every code from 1 upward adds the listed field to those of the codes below it, except where R5 says otherwise.
  - 0: half-second period, no field compared.
  - 1: one second, adds the half-second bit.
  - 2: ten seconds, adds the seconds units digit `sec[3:0]`.
  - 3: one minute, adds the seconds tens digit `sec[7:4]`.
  - 4: ten minutes, adds the minutes units digit `min[3:0]`.
  - 5: one hour, adds the minutes tens digit `min[7:4]`.
  - 6: one day, adds the hour byte.
- R5: Code 7 (one week) compares the weekday in addition to the code-6 fields. Code 8 (one month) drops the weekday and adds the day-of-month byte to the code-6 fields. Code 9 (one year) adds the month byte to the code-8 fields.
- R6: Codes 10 to 15 never produce a pulse, and `alm_active` is not changed by ticks while one of them is set.
- R7: With chime off and repeat count N loaded, the alarm gives exactly N+1 pulses. `alm_active` falls to 0 in the same cycle as the last pulse.
- R8: With chime on, the alarm keeps pulsing on every match and `alm_active` stays 1. A pulse taken with the counter at zero reloads the counter with all ones.
- R9: A tick that arrives in the same cycle as `cfg_we` produces no pulse, whatever the old or new configuration.
- R10: While `alm_active` is 0, no tick produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Half-second evaluation strobe |
| cal_half | input | 1 | Current half-second phase |
| cal_sec | input | 8 | Current seconds, BCD |
| cal_min | input | 8 | Current minutes, BCD |
| cal_hour | input | 8 | Current hour, BCD, 24-hour |
| cal_wday | input | 3 | Current weekday |
| cal_day | input | 8 | Current day of month, BCD |
| cal_mon | input | 8 | Current month, BCD |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value to write |
| cfg_chime | input | 1 | Endless-repeat flag to write |
| cfg_rpt | input | RPT_W | Repeat count to write |
| cfg_ival | input | 4 | Interval code to write |
| cfg_half | input | 1 | Alarm half-second phase |
| cfg_sec | input | 8 | Alarm seconds, BCD |
| cfg_min | input | 8 | Alarm minutes, BCD |
| cfg_hour | input | 8 | Alarm hour, BCD |
| cfg_wday | input | 3 | Alarm weekday |
| cfg_day | input | 8 | Alarm day of month, BCD |
| cfg_mon | input | 8 | Alarm month, BCD |
| alm_pulse | output | 1 | One-cycle alarm event |
| alm_active | output | 1 | Alarm enabled |

## Verification
The bench builds the block with `RPT_W = 3`, so the repeat counter has only eight states. This puts the chime wrap from zero to seven, and a full countdown, within a few dozen ticks. The interval sweep disturbs one alarm field at a time under each of codes 0 to 9. This shows separately for every field whether a code compares it, including the weekday, which only code 7 compares.

// File: rtl/rcal_alarm_pkg.sv
package rcal_alarm_pkg;
   localparam int LANE_W   = 8;
   localparam int NLANE    = 9;
   localparam int WDAY_LN  = 6;
   localparam int IVAL_MAX = 9;

   typedef logic [LANE_W-1:0]            lane_t;
   typedef logic [NLANE-1:0][LANE_W-1:0] lanes_t;

   typedef enum logic [3:0] {
      IV_HALF, IV_SEC, IV_10SEC, IV_MIN, IV_10MIN,
      IV_HOUR, IV_DAY, IV_WEEK, IV_MONTH, IV_YEAR
   } ival_e;

   // Lane order follows the interval ladder: lane l joins at code l+1.
   function automatic lanes_t pack_lanes(input logic       half,
                                         input logic [7:0] sec,
                                         input logic [7:0] min,
                                         input logic [7:0] hour,
                                         input logic [2:0] wday,
                                         input logic [7:0] day,
                                         input logic [7:0] mon);
      lanes_t l;
      l[0] = {7'd0, half};
      l[1] = {4'd0, sec[3:0]};
      l[2] = {4'd0, sec[7:4]};
      l[3] = {4'd0, min[3:0]};
      l[4] = {4'd0, min[7:4]};
      l[5] = hour;
      l[6] = {5'd0, wday};
      l[7] = day;
      l[8] = mon;
      return l;
   endfunction
endpackage

// File: rtl/rcal_mask_decode.sv
module rcal_mask_decode
   import rcal_alarm_pkg::*;
#(
   parameter int NL      = NLANE,
   parameter int WD_LANE = WDAY_LN,
   parameter int TOP_IV  = IVAL_MAX
) (
   input  logic [3:0]    ival,
   output logic          ival_ok,
   output logic [NL-1:0] sel
);
   if (NL != TOP_IV) begin : g_bad_nl
      $error("lane count must equal the highest interval code");
   end

   assign ival_ok = (ival <= 4'(TOP_IV));

   for (genvar l = 0; l < NL; l++) begin : g_lane
      if (l == WD_LANE) begin : g_only
         assign sel[l] = ival_ok && (ival == 4'(l + 1));
      end else begin : g_ladder
         assign sel[l] = ival_ok && (ival >= 4'(l + 1));
      end
   end

   always_comb begin
      AST_SEL_NEEDS_VALID: assert (ival_ok || sel == '0);  // R6
   end
endmodule

// File: rtl/rcal_lane_cmp.sv
module rcal_lane_cmp
   import rcal_alarm_pkg::*;
#(
   parameter int NL = NLANE,
   parameter int LW = LANE_W
) (
   input  logic [NL-1:0][LW-1:0] cur,
   input  logic [NL-1:0][LW-1:0] tgt,
   input  logic [NL-1:0]         sel,
   output logic                  hit
);
   logic [NL-1:0] ok;

   for (genvar l = 0; l < NL; l++) begin : g_cmp
      assign ok[l] = !sel[l] || (cur[l] == tgt[l]);
   end

   assign hit = &ok;
endmodule

// File: rtl/rcal_repeat_ctrl.sv
module rcal_repeat_ctrl #(
   parameter int RPT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_en,
   input  logic             load_chime,
   input  logic [RPT_W-1:0] load_cnt,
   input  logic             fire,
   output logic             en
);
   localparam logic [RPT_W-1:0] CNT_TOP = '1;

   if (RPT_W < 1 || RPT_W > 16) begin : g_bad_w
      $error("RPT_W must be 1..16");
   end

   logic             chime_q;
   logic [RPT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         chime_q <= 1'b0;
         cnt_q   <= '0;
      end else if (load) begin
         en      <= load_en;
         chime_q <= load_chime;
         cnt_q   <= load_cnt;
      end else if (fire) begin
         if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (chime_q) begin
            cnt_q <= CNT_TOP;
         end else begin
            en <= 1'b0;
         end
      end
   end

   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) && en);  // R7
   AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !load && cnt_q == '0 && !chime_q) |=> !en);  // R7
   AST_CHIME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !load && cnt_q == '0 && chime_q) |=> (cnt_q == CNT_TOP) && en);  // R8
endmodule

// File: rtl/rcal_alarm.sv
module rcal_alarm
   import rcal_alarm_pkg::*;
#(
   parameter int RPT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cal_half,
   input  logic [7:0]       cal_sec,
   input  logic [7:0]       cal_min,
   input  logic [7:0]       cal_hour,
   input  logic [2:0]       cal_wday,
   input  logic [7:0]       cal_day,
   input  logic [7:0]       cal_mon,
   input  logic             cfg_we,
   input  logic             cfg_en,
   input  logic             cfg_chime,
   input  logic [RPT_W-1:0] cfg_rpt,
   input  logic [3:0]       cfg_ival,
   input  logic             cfg_half,
   input  logic [7:0]       cfg_sec,
   input  logic [7:0]       cfg_min,
   input  logic [7:0]       cfg_hour,
   input  logic [2:0]       cfg_wday,
   input  logic [7:0]       cfg_day,
   input  logic [7:0]       cfg_mon,
   output logic             alm_pulse,
   output logic             alm_active
);
   lanes_t        tgt_q;
   lanes_t        cur;
   logic [3:0]    ival_q;
   logic          ival_ok;
   logic [NLANE-1:0] sel;
   logic          hit;
   logic          fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q  <= '0;
         ival_q <= 4'(IV_HALF);
      end else if (cfg_we) begin
         tgt_q  <= pack_lanes(cfg_half, cfg_sec, cfg_min, cfg_hour,
                              cfg_wday, cfg_day, cfg_mon);
         ival_q <= cfg_ival;
      end
   end

   assign cur = pack_lanes(cal_half, cal_sec, cal_min, cal_hour,
                           cal_wday, cal_day, cal_mon);

   rcal_mask_decode #(.NL(NLANE), .WD_LANE(WDAY_LN), .TOP_IV(IVAL_MAX)) u_dec (
      .ival    (ival_q),
      .ival_ok (ival_ok),
      .sel     (sel)
   );

   rcal_lane_cmp #(.NL(NLANE), .LW(LANE_W)) u_cmp (
      .cur (cur),
      .tgt (tgt_q),
      .sel (sel),
      .hit (hit)
   );

   // A write owns its cycle: the tick that coincides with it is dropped.
   assign fire = tick && !cfg_we && alm_active && ival_ok && hit;

   rcal_repeat_ctrl #(.RPT_W(RPT_W)) u_rpt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cfg_we),
      .load_en    (cfg_en),
      .load_chime (cfg_chime),
      .load_cnt   (cfg_rpt),
      .fire       (fire),
      .en         (alm_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_pulse <= 1'b0;
      else        alm_pulse <= fire;
   end

   AST_NO_TICK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !alm_pulse);  // R3
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !alm_pulse);  // R9
   AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ival_q > 4'(IVAL_MAX) && !cfg_we) |=> !alm_pulse && $stable(alm_active));  // R6
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !alm_active |=> !alm_pulse);  // R10
   AST_WRITE_LOADS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (alm_active == $past(cfg_en)));  // R2
endmodule

// File: tb/rcal_alarm_bench.sv
module rcal_alarm_bench;
   localparam int RPT_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic cal_half = 1'b1;
   logic [7:0] cal_sec = 8'h37, cal_min = 8'h42, cal_hour = 8'h15;
   logic [2:0] cal_wday = 3'd3;
   logic [7:0] cal_day = 8'h28, cal_mon = 8'h11;
   logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_chime = 1'b0;
   logic [RPT_W-1:0] cfg_rpt = '0;
   logic [3:0] cfg_ival = '0;
   logic cfg_half = 1'b0;
   logic [7:0] cfg_sec = '0, cfg_min = '0, cfg_hour = '0;
   logic [2:0] cfg_wday = '0;
   logic [7:0] cfg_day = '0, cfg_mon = '0;
   logic alm_pulse, alm_active;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rcal_alarm #(.RPT_W(RPT_W)) u_rcal_alarm (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cal_half(cal_half), .cal_sec(cal_sec), .cal_min(cal_min),
      .cal_hour(cal_hour), .cal_wday(cal_wday), .cal_day(cal_day),
      .cal_mon(cal_mon), .cfg_we(cfg_we), .cfg_en(cfg_en),
      .cfg_chime(cfg_chime), .cfg_rpt(cfg_rpt), .cfg_ival(cfg_ival),
      .cfg_half(cfg_half), .cfg_sec(cfg_sec), .cfg_min(cfg_min),
      .cfg_hour(cfg_hour), .cfg_wday(cfg_wday), .cfg_day(cfg_day),
      .cfg_mon(cfg_mon), .alm_pulse(alm_pulse), .alm_active(alm_active)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic alarm_eq_cal();
      cfg_half = cal_half; cfg_sec = cal_sec; cfg_min = cal_min;
      cfg_hour = cal_hour; cfg_wday = cal_wday; cfg_day = cal_day;
      cfg_mon = cal_mon;
   endtask

   task automatic write_cfg(input bit en, input bit chime,
                            input logic [RPT_W-1:0] rpt, input logic [3:0] iv);
      @(negedge clk);
      cfg_we = 1'b1; cfg_en = en; cfg_chime = chime; cfg_rpt = rpt; cfg_ival = iv;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_tick(output bit got);
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      got = alm_pulse;
   endtask

   task automatic t_reset();
      chk(alm_pulse == 1'b0, "R1", alm_pulse, 0);
      chk(alm_active == 1'b0, "R1", alm_active, 0);
   endtask

   task automatic t_write();
      alarm_eq_cal();
      write_cfg(1'b1, 1'b0, '0, 4'd0);
      chk(alm_active == 1'b1, "R2", alm_active, 1);
      write_cfg(1'b0, 1'b0, '0, 4'd0);
      chk(alm_active == 1'b0, "R2", alm_active, 0);
   endtask

   task automatic t_no_tick();
      bit seen = 0;
      alarm_eq_cal();
      write_cfg(1'b1, 1'b0, '0, 4'd9);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (alm_pulse) seen = 1;
      end
      chk(!seen, "R3 no tick", seen, 0);
      chk(alm_active == 1'b1, "R3 still armed", alm_active, 1);
   endtask

   // Code at which each lane joins; the weekday lane is compared only at 7.
   function automatic bit lane_used(input int code, input int lane);
      if (lane == 6) return code == 7;
      return code >= lane + 1;
   endfunction

   task automatic perturb(input int lane);
      case (lane)
         0: cfg_half = ~cal_half;
         1: cfg_sec  = 8'h38;
         2: cfg_sec  = 8'h47;
         3: cfg_min  = 8'h43;
         4: cfg_min  = 8'h52;
         5: cfg_hour = 8'h16;
         6: cfg_wday = 3'd4;
         7: cfg_day  = 8'h29;
         default: cfg_mon = 8'h12;
      endcase
   endtask

   task automatic t_mask_sweep();
      bit got;
      for (int code = 0; code <= 9; code++) begin
         alarm_eq_cal();
         write_cfg(1'b1, 1'b0, '0, 4'(code));
         do_tick(got);
         chk(got == 1'b1, "R4 full match", got, 1);
         for (int lane = 0; lane < 9; lane++) begin
            bit exp;
            alarm_eq_cal();
            perturb(lane);
            write_cfg(1'b1, 1'b0, '0, 4'(code));
            do_tick(got);
            exp = !lane_used(code, lane);
            if (lane == 6 || code >= 7)
               chk(got == exp, "R5 weekday/month/year", got, int'(exp));
            else
               chk(got == exp, "R4 field select", got, int'(exp));
         end
      end
   endtask

   task automatic t_reserved();
      bit got;
      for (int code = 10; code <= 15; code++) begin
         alarm_eq_cal();
         write_cfg(1'b1, 1'b0, '0, 4'(code));
         do_tick(got);
         chk(got == 1'b0, "R6 reserved code", got, 0);
         chk(alm_active == 1'b1, "R6 active kept", alm_active, 1);
      end
   endtask

   task automatic t_countdown();
      bit got;
      int pulses = 0;
      alarm_eq_cal();
      write_cfg(1'b1, 1'b0, 3'd3, 4'd0);
      for (int i = 0; i < 7; i++) begin
         do_tick(got);
         if (got) pulses++;
         if (i == 3) chk(alm_active == 1'b0, "R7 drops with last pulse", alm_active, 0);
         if (i == 2) chk(alm_active == 1'b1, "R7 armed before last", alm_active, 1);
      end
      chk(pulses == 4, "R7 pulse count", pulses, 4);
   endtask

   task automatic t_chime();
      bit got;
      int pulses = 0;
      alarm_eq_cal();
      write_cfg(1'b1, 1'b1, 3'd0, 4'd0);
      for (int i = 0; i < 20; i++) begin
         do_tick(got);
         if (got) pulses++;
      end
      chk(pulses == 20, "R8 endless chime", pulses, 20);
      chk(alm_active == 1'b1, "R8 still active", alm_active, 1);
   endtask

   task automatic t_write_tick();
      bit got;
      alarm_eq_cal();
      write_cfg(1'b1, 1'b0, 3'd2, 4'd0);
      @(negedge clk);
      tick = 1'b1; cfg_we = 1'b1;
      @(negedge clk);
      tick = 1'b0; cfg_we = 1'b0;
      chk(alm_pulse == 1'b0, "R9 write cycle tick", alm_pulse, 0);
      do_tick(got);
      chk(got == 1'b1, "R9 next tick fires", got, 1);
   endtask

   task automatic t_idle();
      bit got;
      alarm_eq_cal();
      write_cfg(1'b0, 1'b1, 3'd5, 4'd0);
      do_tick(got);
      chk(got == 1'b0, "R10 disabled", got, 0);
      do_tick(got);
      chk(got == 1'b0, "R10 disabled again", got, 0);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_no_tick();
      t_mask_sweep();
      t_reserved();
      t_countdown();
      t_chime();
      t_write_tick();
      t_idle();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule